// File: doc/BRIEF.md
# Registered Bidirectional Bus Bridge

This block connects two bidirectional data buses, called A and B, through a datapath of parameterised width (eight bits by default). Each direction owns a storage register. A capture strobe loads it, one strobe per direction. A direction input and an active-low enable decide which bus, if any, the bridge drives. For each direction, a select input picks between the live value on the opposite bus and the value held in that direction's register.

Both buses are split into input, output and output-enable signals, so a pad ring or a wrapper can add the tri-state drivers. The capture strobes are level inputs sampled by one system clock. A register loads only in the clock cycle where its strobe is first seen high. A strobe held high does not load again. Capture never depends on the enable or direction inputs, so data can be stored while both buses are isolated.

Top module: `xcvr_bridge`

## Requirements
- R1: An active-low asynchronous reset (`rst_n`) clears both storage registers to zero. After reset, a stored-source select returns 0 on its output.
- R2: The A-to-B register loads `a_in` at the clock edge where `cap_ab` is sampled high after being sampled low at the previous edge. While `cap_ab` stays high, the register keeps its value.
- R3: The B-to-A register loads `b_in` at the clock edge where `cap_ba` is sampled high after being sampled low at the previous edge. While `cap_ba` stays high, the register keeps its value.
- R4: Capture into either register is unaffected by `en_n` and `dir_b`. A value captured while `en_n` is 1 can be read back later through the stored-source select.
- R5: While `en_n` is 1, both `a_oe` and `b_oe` are 0.
- R6: While `en_n` is 0, `dir_b` = 0 gives `a_oe` = 1 and `b_oe` = 0, and `dir_b` = 1 gives `b_oe` = 1 and `a_oe` = 0.
- R7: `a_out` equals `b_in` in the same cycle when `sel_ba_stored` = 0. It equals the B-to-A register when `sel_ba_stored` = 1.
- R8: `b_out` equals `a_in` in the same cycle when `sel_ab_stored` = 0. It equals the A-to-B register when `sel_ab_stored` = 1.
- R9: `a_oe` and `b_oe` are never both 1, for any combination of inputs.
- R10: The output enables depend only on `en_n` and `dir_b`. They follow R5 and R6 while reset is asserted as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the capture strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the storage registers |
| en_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_b | input | 1 | Direction: 0 drives bus A, 1 drives bus B |
| sel_ab_stored | input | 1 | 1: `b_out` shows the A-to-B register; 0: live `a_in` |
| sel_ba_stored | input | 1 | 1: `a_out` shows the B-to-A register; 0: live `b_in` |
| cap_ab | input | 1 | Capture strobe for the A-to-B register (rising level detected) |
| cap_ba | input | 1 | Capture strobe for the B-to-A register (rising level detected) |
| a_in | input | DATA_W | Value present on bus A |
| a_out | output | DATA_W | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | DATA_W | Value present on bus B |
| b_out | output | DATA_W | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The enables and the live-data paths are combinational, so their results are due in the same cycle as the stimulus. A stored value appears on an output from the clock edge at which the rising strobe is sampled. It is visible for the whole cycle that follows that edge.

The bench changes every input just after a falling edge and samples every output 2 ns later, before the next rising edge. Its reference model updates its own registers only at rising edges, so each expectation already contains every capture that has taken effect. A reset that lands mid-cycle clears the model at the same moment the inputs change.

// File: rtl/xcvr_bridge_pkg.sv
package xcvr_bridge_pkg;

  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
  localparam int unsigned NUM_DIR = 2;

  typedef struct packed {
    logic a_oe;
    logic b_oe;
  } oe_pair_t;

  // Only one side may ever be driven; isolation overrides direction.
  function automatic oe_pair_t decode_oe(input logic en_n, input logic dir_b);
    oe_pair_t r;
    r.a_oe = ~en_n & ~dir_b;
    r.b_oe = ~en_n &  dir_b;
    return r;
  endfunction

  function automatic logic pick_bit(input logic sel_stored, input logic live_bit,
                                    input logic stored_bit);
    return sel_stored ? stored_bit : live_bit;
  endfunction

  function automatic logic is_rise(input logic now_v, input logic before_v);
    return now_v & ~before_v;
  endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic strobe,
  output logic rise
);
  import xcvr_bridge_pkg::*;

  // History register is deliberately unreset: it always mirrors the
  // strobe seen at the previous edge, even across a reset.
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= strobe;
  end

  assign rise = is_rise(strobe, prev_q);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/xcvr_lane_mux.sv
module xcvr_lane_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sel_stored,
  input  logic [DATA_W-1:0] live,
  input  logic [DATA_W-1:0] stored,
  output logic [DATA_W-1:0] y
);
  import xcvr_bridge_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign y[i] = pick_bit(sel_stored, live[i], stored[i]);
  end
endmodule

// File: rtl/xcvr_port_ctrl.sv
module xcvr_port_ctrl (
  input  logic en_n,
  input  logic dir_b,
  output logic a_oe,
  output logic b_oe
);
  import xcvr_bridge_pkg::*;

  oe_pair_t oe;

  always_comb begin
    oe = decode_oe(en_n, dir_b);
  end

  assign a_oe = oe.a_oe;
  assign b_oe = oe.b_oe;
endmodule

// File: rtl/xcvr_bridge.sv
module xcvr_bridge #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              dir_b,
  input  logic              sel_ab_stored,
  input  logic              sel_ba_stored,
  input  logic              cap_ab,
  input  logic              cap_ba,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe
);
  import xcvr_bridge_pkg::*;

  // Per-direction views: index DIR_AB carries A toward B, DIR_BA the reverse.
  logic [DATA_W-1:0] src    [NUM_DIR];
  logic [DATA_W-1:0] stored [NUM_DIR];
  logic [DATA_W-1:0] dst    [NUM_DIR];
  logic              strb   [NUM_DIR];
  logic              rise   [NUM_DIR];
  logic              sel    [NUM_DIR];

  assign src[DIR_AB]  = a_in;
  assign src[DIR_BA]  = b_in;
  assign strb[DIR_AB] = cap_ab;
  assign strb[DIR_BA] = cap_ba;
  assign sel[DIR_AB]  = sel_ab_stored;
  assign sel[DIR_BA]  = sel_ba_stored;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_strobe_edge u_edge (
      .clk    (clk),
      .strobe (strb[d]),
      .rise   (rise[d])
    );

    xcvr_store #(.DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rise[d]),
      .d     (src[d]),
      .q     (stored[d])
    );

    xcvr_lane_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_stored (sel[d]),
      .live       (src[d]),
      .stored     (stored[d]),
      .y          (dst[d])
    );
  end

  xcvr_port_ctrl u_ctrl (
    .en_n  (en_n),
    .dir_b (dir_b),
    .a_oe  (a_oe),
    .b_oe  (b_oe)
  );

  assign b_out = dst[DIR_AB];
  assign a_out = dst[DIR_BA];

  // Named internal events for the bound checker.
  logic [DATA_W-1:0] ab_q;
  logic [DATA_W-1:0] ba_q;
  logic              ab_rise;
  logic              ba_rise;
  assign ab_q    = stored[DIR_AB];
  assign ba_q    = stored[DIR_BA];
  assign ab_rise = rise[DIR_AB];
  assign ba_rise = rise[DIR_BA];
endmodule

// File: rtl/xcvr_bridge_chk.sv
module xcvr_bridge_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic              dir_b,
  input logic              sel_ab_stored,
  input logic              sel_ba_stored,
  input logic              cap_ab,
  input logic              cap_ba,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic [DATA_W-1:0] a_out,
  input logic [DATA_W-1:0] b_out,
  input logic              a_oe,
  input logic              b_oe,
  input logic [DATA_W-1:0] ab_q,
  input logic [DATA_W-1:0] ba_q
);
  // R9
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));

  // R5
  isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (!a_oe && !b_oe));

  // R6
  drive_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !dir_b) |-> (a_oe && !b_oe));

  // R6
  drive_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && dir_b) |-> (b_oe && !a_oe));

  // R2
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ab && !$past(cap_ab)) |=> (ab_q == $past(a_in)));

  // R2
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_ab && !$past(cap_ab)) |=> $stable(ab_q));

  // R3
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ba && !$past(cap_ba)) |=> (ba_q == $past(b_in)));

  // R3
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_ba && !$past(cap_ba)) |=> $stable(ba_q));

  // R7
  a_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_out == (sel_ba_stored ? ba_q : b_in));

  // R8
  b_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_out == (sel_ab_stored ? ab_q : a_in));
endmodule

bind xcvr_bridge xcvr_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_n          (en_n),
  .dir_b         (dir_b),
  .sel_ab_stored (sel_ab_stored),
  .sel_ba_stored (sel_ba_stored),
  .cap_ab        (cap_ab),
  .cap_ba        (cap_ba),
  .a_in          (a_in),
  .b_in          (b_in),
  .a_out         (a_out),
  .b_out         (b_out),
  .a_oe          (a_oe),
  .b_oe          (b_oe),
  .ab_q          (ab_q),
  .ba_q          (ba_q)
);

// File: tb/tb_xcvr_bridge.sv
module tb_xcvr_bridge;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic         rst_n = 1'b0, en_n = 1'b1, dir_b = 1'b0;
  logic         sel_ab_stored = 1'b0, sel_ba_stored = 1'b0;
  logic         cap_ab = 1'b0, cap_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  xcvr_bridge #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir_b(dir_b),
    .sel_ab_stored(sel_ab_stored), .sel_ba_stored(sel_ba_stored),
    .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct {
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;
    string        note;
  } item_t;

  item_t  sb_q[$];
  event   chk_ev;
  int     checks = 0;
  int     errors = 0;
  bit     done   = 1'b0;

  // Reference model state, advanced only at rising edges.
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic         m_pab = 1'b0, m_pba = 1'b0;

  task automatic check(input bit ok, input string req, input string note,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s): actual=%h expected=%h", req, note, act, exp);
    end
  endtask

  task automatic apply(input logic rst, input logic en, input logic dir,
                       input logic sab, input logic sba, input logic cab,
                       input logic cba, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string note);
    item_t it;
    @(posedge clk);
    if (rst_n) begin
      if (cap_ab && !m_pab) m_ab = a_in;
      if (cap_ba && !m_pba) m_ba = b_in;
    end
    m_pab = cap_ab;
    m_pba = cap_ba;
    @(negedge clk);
    rst_n = rst; en_n = en; dir_b = dir;
    sel_ab_stored = sab; sel_ba_stored = sba;
    cap_ab = cab; cap_ba = cba; a_in = a; b_in = b;
    if (!rst) begin
      m_ab = '0;
      m_ba = '0;
    end
    it.a_oe  = (en == 1'b0) && (dir == 1'b0);
    it.b_oe  = (en == 1'b0) && (dir == 1'b1);
    it.a_out = sba ? m_ba : b;
    it.b_out = sab ? m_ab : a;
    it.note  = note;
    sb_q.push_back(it);
    -> chk_ev;
  endtask

  // Monitor: pops one expected item per stimulus and compares.
  initial begin
    forever begin
      @(chk_ev);
      #2;
      while (sb_q.size() > 0) begin
        item_t e;
        e = sb_q.pop_front();
        check(a_out == e.a_out, "R7", e.note, a_out, e.a_out);
        check(b_out == e.b_out, "R8", e.note, b_out, e.b_out);
        check(a_oe == e.a_oe, en_n ? "R5" : "R6", e.note, {7'd0, a_oe}, {7'd0, e.a_oe});
        check(b_oe == e.b_oe, en_n ? "R5" : "R6", e.note, {7'd0, b_oe}, {7'd0, e.b_oe});
        check(!(a_oe && b_oe), "R9", e.note, {6'd0, a_oe, b_oe}, 8'd0);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 R10: in reset the stored paths read 0 and enables still decode.
    apply(0, 0, 0, 1, 1, 0, 0, 8'hA5, 8'h3C, "R1 R10 reset, drive A");
    apply(0, 0, 1, 1, 1, 0, 0, 8'hFF, 8'hEE, "R1 R10 reset, drive B");
    apply(0, 1, 0, 1, 1, 0, 0, 8'h11, 8'h22, "R10 reset, isolated");
    apply(1, 0, 0, 1, 1, 0, 0, 8'h77, 8'h66, "R1 after release");
    // R2: rising strobe loads 5A; held strobe does not reload 33.
    apply(1, 0, 1, 1, 0, 1, 0, 8'h5A, 8'h00, "R2 strobe rise");
    apply(1, 0, 1, 1, 0, 1, 0, 8'h33, 8'h00, "R2 strobe held");
    apply(1, 0, 1, 1, 0, 0, 0, 8'h44, 8'h00, "R2 stored 5A kept");
    // R3: same for the B-to-A register.
    apply(1, 0, 0, 0, 1, 0, 1, 8'h00, 8'hC3, "R3 strobe rise");
    apply(1, 0, 0, 0, 1, 0, 1, 8'h00, 8'h99, "R3 strobe held");
    apply(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h10, "R3 stored C3 kept");
    // R4: capture while isolated, read back later.
    apply(1, 1, 0, 0, 0, 1, 1, 8'h81, 8'h18, "R4 capture isolated");
    apply(1, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R4 isolated idle");
    apply(1, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R4 readback AB");
    apply(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R4 readback BA");
    // R7 R8: live paths.
    apply(1, 0, 0, 0, 0, 0, 0, 8'hDE, 8'hAD, "R7 R8 live");
    apply(1, 0, 1, 0, 0, 0, 0, 8'hBE, 8'hEF, "R7 R8 live");
    // Random phase with occasional reset pulses (R9 every cycle).
    for (int i = 0; i < 600; i++) begin
      logic r;
      r = ($urandom_range(0, 63) != 0);
      apply(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), "random");
    end
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule